// File: doc/BRIEF.md
# Dual-Mode Host Parallel Slave Port

This block is a slave port. It lets an external host processor trade data with a 24-bit core over a byte-wide bus. The host bus can run in either of two modes. In separate-address mode, three pins form the register index directly. In multiplexed mode, the eight data pins carry an address whenever the strobe pin is high. The same strobe pin serves as index bit 0 in the separate-address mode. The other two address pins serve as index bits 1 and 2 in separate-address mode, and as upper page bits in multiplexed mode. Everything runs on one clock. Each host access is a one-cycle pulse on the chip-select line together with a read or write line.

Each direction has two buffers and both directions work at the same time. Going to the core, host bytes are packed into a word of 8, 16 or 24 bits. The word is handed to the core when the host writes the low byte. Going to the host, the core's word waits in a holding register and then moves into a host-side output register, where the host reads it byte by byte.

The core reaches the port through eight registers. Its ready flags can be polled, can raise an interrupt, or can drive DMA requests. A group of spare pins can be used as general-purpose I/O, with per-pin enable, direction and data.

Top module: `hpar_port`

## Requirements
- R1: After reset the receive-full flag is 0 and the transmit-empty flag is 1. core_irq, both DMA requests, host_d_oe and every gp_oe bit are 0.
- R2: Host byte index 5 is the high byte, 6 the middle byte and 7 the low byte. In 24-bit mode, a core read of address 2 returns {high, middle, low}. Status bit 0 at core address 1 (receive full) is set only by the low-byte write.
- R3: With the word-size field at 1 (16-bit), host writes to the high byte are ignored and the core word is {8'h00, middle, low}. With the field at 0 (8-bit), the core word is {16'h0000, low}. Field values 2 and 3 both select 24-bit mode.
- R4: A core read of address 2 clears receive full. If a second host word arrives while receive full is set, that word waits. While it waits, host status bit 0 (index 0) reads 0 and host byte writes are ignored. The waiting word reaches the core one cycle after the core read.
- R5: A core write to address 3 clears transmit empty (status bit 1). The word moves to the host output register on the next cycle if that register is free, and transmit empty returns to 1. Otherwise transmit empty stays 0 until the host reads byte index 7. Host status bit 1 shows that a word is waiting for the host.
- R6: A host read returns its byte on host_d_o, with host_d_oe high, in the cycle after the read pulse. In 16-bit mode the high byte reads 0. In 8-bit mode both the high and middle bytes read 0.
- R7: In separate-address mode the register index is {host_a2_a9, host_a1_a8, host_as_a0}. Indexes with no register read 0, and writes to them have no effect.
- R8: In multiplexed mode, a cycle with chip select and the strobe pin high latches the index from host_d_i[2:0]. The latched index is valid only if host_d_i[7:3] is 0 and {host_a2_a9, host_a1_a8} equals MUX_PAGE. Data accesses made under an invalid latch are ignored.
- R9: Core address 0 is the control register and reads back as written. Its fields are: bit 0 multiplexed mode, bits 2:1 word size, bit 3 receive interrupt enable, bit 4 transmit interrupt enable, bit 5 DMA enable, bit 6 host enable. While host enable is 0, every host access is ignored.
- R10: core_irq = (bit3 & receive full) | (bit4 & transmit empty). core_dma_rx = bit5 & receive full. core_dma_tx = bit5 & transmit empty.
- R11: Core addresses 4, 5 and 6 hold the per-pin GPIO enable, direction and data. gp_oe = enable & direction, and gp_o = enable & data. A read of address 6 returns, for enabled pins, the data bit for outputs and gp_i for inputs. Pins that are not enabled read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read pulse |
| host_wr | input | 1 | Host write pulse |
| host_as_a0 | input | 1 | Address strobe (multiplexed) or index bit 0 |
| host_a1_a8 | input | 1 | Page bit 0 (multiplexed) or index bit 1 |
| host_a2_a9 | input | 1 | Page bit 1 (multiplexed) or index bit 2 |
| host_d_i | input | 8 | Host data/address in |
| host_d_o | output | 8 | Host read data |
| host_d_oe | output | 1 | Host data drive enable |
| core_addr | input | 3 | Core register address |
| core_we | input | 1 | Core write strobe |
| core_re | input | 1 | Core read strobe |
| core_wdata | input | 24 | Core write data |
| core_rdata | output | 24 | Core read data, one cycle after core_re |
| core_irq | output | 1 | Interrupt request |
| core_dma_rx | output | 1 | DMA request, word ready for core |
| core_dma_tx | output | 1 | DMA request, room for core word |
| gp_i | input | GP_N | GPIO pin inputs |
| gp_o | output | GP_N | GPIO pin outputs |
| gp_oe | output | GP_N | GPIO drive enables |

## Verification
The bench targets four kinds of error.

- Back-to-back host words. A design that drops or overwrites the second word would return corrupt data on the second core read.
- The low-byte trigger in the two narrower modes. A port that still honours high-byte writes in 16-bit mode would leak that byte into bits 23:16.
- Reads of the host output register. A port that lets its transmit holding register move into an output register that is still full would skip a word.
- Multiplexed mode with a wrong page or a nonzero upper address. A decoder that ignores the latch check would accept stray writes and set receive full.

A reference model compares the interrupt, DMA and GPIO outputs on every clock, so a flag that settles one cycle late is caught.

// File: rtl/hpar_pkg.sv
package hpar_pkg;

  localparam int CW = 24;

  typedef enum logic [1:0] {
    WS_8   = 2'd0,
    WS_16  = 2'd1,
    WS_24  = 2'd2,
    WS_24B = 2'd3
  } wsize_e;

  typedef enum logic [2:0] {
    CR_CTRL = 3'd0,
    CR_STAT = 3'd1,
    CR_RX   = 3'd2,
    CR_TX   = 3'd3,
    CR_SEL  = 3'd4,
    CR_DIR  = 3'd5,
    CR_DAT  = 3'd6,
    CR_RSV  = 3'd7
  } creg_e;

  localparam logic [2:0] HI_STAT = 3'd0;
  localparam logic [2:0] HI_HIGH = 3'd5;
  localparam logic [2:0] HI_MID  = 3'd6;
  localparam logic [2:0] HI_LOW  = 3'd7;

  typedef struct packed {
    logic   host_en;
    logic   dma_en;
    logic   ie_tx;
    logic   ie_rx;
    wsize_e wsize;
    logic   mux;
  } ctrl_t;

  function automatic logic uses_high(input wsize_e ws);
    return (ws == WS_24) || (ws == WS_24B);
  endfunction

  function automatic logic uses_mid(input wsize_e ws);
    return ws != WS_8;
  endfunction

  function automatic logic [CW-1:0] pack_word(input wsize_e ws, input logic [7:0] h,
                                              input logic [7:0] m, input logic [7:0] l);
    case (ws)
      WS_8:    return {16'h0000, l};
      WS_16:   return {8'h00, m, l};
      default: return {h, m, l};
    endcase
  endfunction

endpackage

// File: rtl/hpar_addr_dec.sv
module hpar_addr_dec #(
  parameter logic [1:0] MUX_PAGE = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mux,
  input  logic       en,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       as_a0,
  input  logic       a1_a8,
  input  logic       a2_a9,
  input  logic [7:0] d_i,
  output logic       wr_evt,
  output logic       rd_evt,
  output logic [2:0] idx
);

  logic [2:0] lat_idx;
  logic       lat_ok;
  logic       acc;

  // address phase of the multiplexed bus
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_idx <= '0;
      lat_ok  <= 1'b0;
    end else if (en && mux && cs && as_a0) begin
      lat_idx <= d_i[2:0];
      lat_ok  <= (d_i[7:3] == 5'd0) && ({a2_a9, a1_a8} == MUX_PAGE);
    end
  end

  assign acc    = en && cs && (mux ? (!as_a0 && lat_ok) : 1'b1);
  assign wr_evt = acc && wr;
  assign rd_evt = acc && rd && !wr;
  assign idx    = mux ? lat_idx : {a2_a9, a1_a8, as_a0};

endmodule

// File: rtl/hpar_rx_path.sv
module hpar_rx_path
  import hpar_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  wsize_e        wsize,
  input  logic          wr_evt,
  input  logic [2:0]    idx,
  input  logic [7:0]    d_i,
  input  logic          core_rd,
  output logic [CW-1:0] rx_word,
  output logic          rx_full,
  output logic          pend
);

  logic [7:0] st_h, st_m, st_l;
  logic       wr_ok, lo_wr;

  assign wr_ok = wr_evt && !pend;
  assign lo_wr = wr_ok && (idx == HI_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_h    <= '0;
      st_m    <= '0;
      st_l    <= '0;
      rx_word <= '0;
      rx_full <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr_ok && idx == HI_HIGH && uses_high(wsize)) st_h <= d_i;
      if (wr_ok && idx == HI_MID && uses_mid(wsize))   st_m <= d_i;
      if (lo_wr) st_l <= d_i;
      if (core_rd) rx_full <= 1'b0;
      // second stage hands over once the core has drained the first
      if (pend && !rx_full) begin
        rx_word <= pack_word(wsize, st_h, st_m, st_l);
        rx_full <= 1'b1;
        pend    <= 1'b0;
      end
      if (lo_wr) begin
        if (!rx_full) begin
          rx_word <= pack_word(wsize, st_h, st_m, d_i);
          rx_full <= 1'b1;
        end else begin
          pend <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hpar_tx_path.sv
module hpar_tx_path
  import hpar_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  wsize_e        wsize,
  input  logic          core_wr,
  input  logic [CW-1:0] core_wdata,
  input  logic          rd_evt,
  input  logic [2:0]    idx,
  output logic          tx_empty,
  output logic          out_full,
  output logic [7:0]    rd_byte
);

  logic [CW-1:0] tx_hold, out_w;
  logic          tx_full, lo_rd, move;

  assign lo_rd    = rd_evt && (idx == HI_LOW) && out_full;
  assign move     = tx_full && !out_full;
  assign tx_empty = !tx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold  <= '0;
      tx_full  <= 1'b0;
      out_w    <= '0;
      out_full <= 1'b0;
    end else begin
      if (move) begin
        out_w    <= tx_hold;
        out_full <= 1'b1;
        tx_full  <= 1'b0;
      end
      if (core_wr) begin
        tx_hold <= core_wdata;
        tx_full <= 1'b1;
      end
      if (lo_rd) out_full <= 1'b0;
    end
  end

  always_comb begin
    case (idx)
      HI_HIGH: rd_byte = uses_high(wsize) ? out_w[23:16] : 8'h00;
      HI_MID:  rd_byte = uses_mid(wsize) ? out_w[15:8] : 8'h00;
      HI_LOW:  rd_byte = out_w[7:0];
      default: rd_byte = 8'h00;
    endcase
  end

endmodule

// File: rtl/hpar_gpio.sv
module hpar_gpio #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_sel,
  input  logic         we_dir,
  input  logic         we_dat,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] gp_i,
  output logic [N-1:0] sel,
  output logic [N-1:0] dir,
  output logic [N-1:0] dat,
  output logic [N-1:0] rd_val,
  output logic [N-1:0] gp_o,
  output logic [N-1:0] gp_oe
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      dir <= '0;
      dat <= '0;
    end else begin
      if (we_sel) sel <= wdata;
      if (we_dir) dir <= wdata;
      if (we_dat) dat <= wdata;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign gp_oe[i]  = sel[i] & dir[i];
    assign gp_o[i]   = sel[i] & dat[i];
    assign rd_val[i] = sel[i] & (dir[i] ? dat[i] : gp_i[i]);
  end

endmodule

// File: rtl/hpar_port.sv
module hpar_port
  import hpar_pkg::*;
#(
  parameter int         GP_N     = 16,
  parameter logic [1:0] MUX_PAGE = 2'b00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_cs,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic            host_as_a0,
  input  logic            host_a1_a8,
  input  logic            host_a2_a9,
  input  logic [7:0]      host_d_i,
  output logic [7:0]      host_d_o,
  output logic            host_d_oe,
  input  logic [2:0]      core_addr,
  input  logic            core_we,
  input  logic            core_re,
  input  logic [CW-1:0]   core_wdata,
  output logic [CW-1:0]   core_rdata,
  output logic            core_irq,
  output logic            core_dma_rx,
  output logic            core_dma_tx,
  input  logic [GP_N-1:0] gp_i,
  output logic [GP_N-1:0] gp_o,
  output logic [GP_N-1:0] gp_oe
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t           ctrl;
  logic            h_wr, h_rd;
  logic [2:0]      h_idx;
  logic            rx_full, rx_pend, tx_empty, out_full;
  logic [CW-1:0]   rx_word;
  logic [7:0]      tx_byte;
  logic [GP_N-1:0] gp_sel, gp_dir, gp_dat, gp_rd;
  logic            core_rd_rx, core_wr_tx;

  assign core_rd_rx = core_re && (core_addr == CR_RX);
  assign core_wr_tx = core_we && (core_addr == CR_TX);

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (core_we && core_addr == CR_CTRL) ctrl <= ctrl_t'(core_wdata[CTRL_W-1:0]);
  end

  hpar_addr_dec #(.MUX_PAGE(MUX_PAGE)) u_dec (
    .clk(clk), .rst(rst), .mux(ctrl.mux), .en(ctrl.host_en),
    .cs(host_cs), .rd(host_rd), .wr(host_wr),
    .as_a0(host_as_a0), .a1_a8(host_a1_a8), .a2_a9(host_a2_a9), .d_i(host_d_i),
    .wr_evt(h_wr), .rd_evt(h_rd), .idx(h_idx)
  );

  hpar_rx_path u_rx (
    .clk(clk), .rst(rst), .wsize(ctrl.wsize), .wr_evt(h_wr), .idx(h_idx),
    .d_i(host_d_i), .core_rd(core_rd_rx),
    .rx_word(rx_word), .rx_full(rx_full), .pend(rx_pend)
  );

  hpar_tx_path u_tx (
    .clk(clk), .rst(rst), .wsize(ctrl.wsize), .core_wr(core_wr_tx),
    .core_wdata(core_wdata), .rd_evt(h_rd), .idx(h_idx),
    .tx_empty(tx_empty), .out_full(out_full), .rd_byte(tx_byte)
  );

  hpar_gpio #(.N(GP_N)) u_gpio (
    .clk(clk), .rst(rst),
    .we_sel(core_we && core_addr == CR_SEL),
    .we_dir(core_we && core_addr == CR_DIR),
    .we_dat(core_we && core_addr == CR_DAT),
    .wdata(core_wdata[GP_N-1:0]), .gp_i(gp_i),
    .sel(gp_sel), .dir(gp_dir), .dat(gp_dat), .rd_val(gp_rd),
    .gp_o(gp_o), .gp_oe(gp_oe)
  );

  // core read port, one cycle latency
  always_ff @(posedge clk) begin
    if (rst) begin
      core_rdata <= '0;
    end else if (core_re) begin
      case (creg_e'(core_addr))
        CR_CTRL: core_rdata <= CW'(ctrl);
        CR_STAT: core_rdata <= CW'({tx_empty, rx_full});
        CR_RX:   core_rdata <= rx_word;
        CR_SEL:  core_rdata <= CW'(gp_sel);
        CR_DIR:  core_rdata <= CW'(gp_dir);
        CR_DAT:  core_rdata <= CW'(gp_rd);
        default: core_rdata <= '0;
      endcase
    end
  end

  // host read port, one cycle latency
  always_ff @(posedge clk) begin
    if (rst) begin
      host_d_o  <= '0;
      host_d_oe <= 1'b0;
    end else begin
      host_d_oe <= h_rd;
      if (h_rd) host_d_o <= (h_idx == HI_STAT) ? {6'b0, out_full, !rx_pend} : tx_byte;
    end
  end

  assign core_irq    = (ctrl.ie_rx & rx_full) | (ctrl.ie_tx & tx_empty);
  assign core_dma_rx = ctrl.dma_en & rx_full;
  assign core_dma_tx = ctrl.dma_en & tx_empty;

endmodule

// File: rtl/hpar_port_chk.sv
module hpar_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       core_we,
  input logic       core_re,
  input logic [2:0] core_addr,
  input logic       rx_full,
  input logic       rx_pend,
  input logic       tx_empty,
  input logic       out_full,
  input logic       h_wr,
  input logic       h_rd,
  input logic [2:0] h_idx,
  input logic       host_d_oe
);

  AST_RX_SET_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> ($past(h_wr && h_idx == 3'd7 && !rx_pend) || $past(rx_pend))); // R2

  AST_RX_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (core_re && core_addr == 3'd2 && rx_full && !rx_pend) |=> !rx_full); // R4

  AST_TX_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (core_we && core_addr == 3'd3) |=> !tx_empty); // R5

  AST_OUT_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
    (out_full && !(h_rd && h_idx == 3'd7)) |=> out_full); // R5

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    host_d_oe |-> $past(h_rd)); // R6

endmodule

bind hpar_port hpar_port_chk u_chk (
  .clk(clk), .rst(rst), .core_we(core_we), .core_re(core_re), .core_addr(core_addr),
  .rx_full(rx_full), .rx_pend(rx_pend), .tx_empty(tx_empty), .out_full(out_full),
  .h_wr(h_wr), .h_rd(h_rd), .h_idx(h_idx), .host_d_oe(host_d_oe)
);

// File: tb/hpar_port_test.sv
module hpar_port_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 0, host_rd = 0, host_wr = 0;
  logic        host_as_a0 = 0, host_a1_a8 = 0, host_a2_a9 = 0;
  logic [7:0]  host_d_i = 0;
  logic [7:0]  host_d_o;
  logic        host_d_oe;
  logic [2:0]  core_addr = 0;
  logic        core_we = 0, core_re = 0;
  logic [23:0] core_wdata = 0;
  logic [23:0] core_rdata;
  logic        core_irq, core_dma_rx, core_dma_tx;
  logic [15:0] gp_i = 16'h1234;
  logic [15:0] gp_o, gp_oe;

  always #2 clk = ~clk;

  hpar_port uut (.*);

  int total = 0, bad = 0;
  bit cmp_on = 0;

  // reference model state
  bit          m_mux = 0, m_ierx = 0, m_ietx = 0, m_dma = 0, m_hen = 0;
  int          m_ws = 0;
  bit          m_rx_full = 0, m_pend = 0, m_tx_full = 0, m_out_full = 0;
  logic [23:0] m_rx_word = 0, m_stage = 0, m_tx_word = 0, m_out_word = 0;
  logic [7:0]  sh = 0, sm = 0;
  logic [15:0] m_sel = 0, m_dir = 0, m_dat = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pk(input int ws, input logic [7:0] h, m, l);
    if (ws == 0) return {16'h0, l};
    if (ws == 1) return {8'h0, m, l};
    return {h, m, l};
  endfunction

  always @(negedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R10 irq", core_irq, (m_ierx & m_rx_full) | (m_ietx & !m_tx_full));
      chk("R10 dma_rx", core_dma_rx, m_dma & m_rx_full);
      chk("R10 dma_tx", core_dma_tx, m_dma & !m_tx_full);
      chk("R11 gp_oe", gp_oe, m_sel & m_dir);
      chk("R11 gp_o", gp_o, m_sel & m_dat);
    end
  end

  task automatic core_wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); core_addr = a; core_wdata = d; core_we = 1;
    @(negedge clk); core_we = 0;
    case (a)
      3'd0: begin
        m_mux = d[0]; m_ws = d[2:1]; m_ierx = d[3]; m_ietx = d[4]; m_dma = d[5]; m_hen = d[6];
      end
      3'd3: begin
        m_tx_word = d; m_tx_full = 1;
        if (!m_out_full) begin
          @(negedge clk);
          m_out_word = m_tx_word; m_out_full = 1; m_tx_full = 0;
        end
      end
      3'd4: m_sel = d[15:0];
      3'd5: m_dir = d[15:0];
      3'd6: m_dat = d[15:0];
      default: ;
    endcase
  endtask

  task automatic core_rd(input logic [2:0] a, input logic [23:0] exp, input string tag);
    @(negedge clk); core_addr = a; core_re = 1;
    @(negedge clk); core_re = 0;
    chk(tag, core_rdata, exp);
    if (a == 3'd2 && m_rx_full) begin
      m_rx_full = 0;
      if (m_pend) begin
        @(negedge clk);
        m_rx_word = m_stage; m_rx_full = 1; m_pend = 0;
      end
    end
  endtask

  function automatic logic [23:0] stat_exp();
    return {22'h0, !m_tx_full, m_rx_full};
  endfunction

  // bad: 0 good, 1 wrong page, 2 nonzero upper address bits (multiplexed only)
  task automatic host_cycle(input bit is_wr, input logic [2:0] idx, input logic [7:0] wd,
                            input int bad);
    if (m_mux) begin
      @(negedge clk);
      host_cs = 1; host_as_a0 = 1;
      host_d_i = (bad == 2) ? {5'b10000, idx} : {5'b00000, idx};
      {host_a2_a9, host_a1_a8} = (bad == 1) ? 2'b11 : 2'b00;
      @(negedge clk);
      host_as_a0 = 0; host_a1_a8 = 0; host_a2_a9 = 0;
      host_d_i = wd; host_wr = is_wr; host_rd = !is_wr;
    end else begin
      @(negedge clk);
      host_cs = 1; {host_a2_a9, host_a1_a8, host_as_a0} = idx;
      host_d_i = wd; host_wr = is_wr; host_rd = !is_wr;
    end
    @(negedge clk);
    host_cs = 0; host_wr = 0; host_rd = 0; host_d_i = 0;
    host_as_a0 = 0; host_a1_a8 = 0; host_a2_a9 = 0;
  endtask

  task automatic host_wr_b(input logic [2:0] idx, input logic [7:0] b, input int bad = 0);
    host_cycle(1, idx, b, bad);
    if (m_hen && bad == 0 && !m_pend) begin
      if (idx == 3'd5 && m_ws >= 2) sh = b;
      if (idx == 3'd6 && m_ws != 0) sm = b;
      if (idx == 3'd7) begin
        if (!m_rx_full) begin m_rx_word = pk(m_ws, sh, sm, b); m_rx_full = 1; end
        else begin m_stage = pk(m_ws, sh, sm, b); m_pend = 1; end
      end
    end
  endtask

  task automatic host_rd_b(input logic [2:0] idx, input string tag, input int bad = 0);
    logic [7:0] exp;
    bit valid;
    valid = m_hen && (bad == 0 || !m_mux);
    case (idx)
      3'd0: exp = {6'b0, m_out_full, !m_pend};
      3'd5: exp = (m_ws >= 2) ? m_out_word[23:16] : 8'h00;
      3'd6: exp = (m_ws != 0) ? m_out_word[15:8] : 8'h00;
      3'd7: exp = m_out_word[7:0];
      default: exp = 8'h00;
    endcase
    host_cycle(0, idx, 8'h00, bad);
    if (valid) begin
      chk({tag, " oe"}, host_d_oe, 1);
      chk(tag, host_d_o, exp);
      if (idx == 3'd7 && m_out_full) begin
        m_out_full = 0;
        if (m_tx_full) begin
          @(negedge clk);
          m_out_word = m_tx_word; m_out_full = 1; m_tx_full = 0;
        end
      end
    end else begin
      chk({tag, " ignored oe"}, host_d_oe, 0);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog (R1-R11 run) act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 host_d_oe", host_d_oe, 0);
    chk("R1 gp_oe", gp_oe, 0);
    chk("R1 irq", core_irq, 0);
    core_rd(3'd1, 24'h000002, "R1 status");

    // R9 control readback, 24-bit, host enabled
    core_wr(3'd0, 24'h44);
    core_rd(3'd0, 24'h44, "R9 ctrl readback");

    // R2 24-bit packing, rx_full only on low byte
    host_wr_b(3'd5, 8'h12);
    host_wr_b(3'd6, 8'h34);
    core_rd(3'd1, stat_exp(), "R2 no full before low");
    host_wr_b(3'd7, 8'h56);
    core_rd(3'd1, stat_exp(), "R2 full after low");
    core_rd(3'd2, 24'h123456, "R2 rx word");
    core_rd(3'd1, stat_exp(), "R2 cleared");

    // R4 double buffering
    host_wr_b(3'd5, 8'h0A); host_wr_b(3'd6, 8'h0B); host_wr_b(3'd7, 8'h0C);
    host_wr_b(3'd5, 8'h01); host_wr_b(3'd6, 8'h02); host_wr_b(3'd7, 8'h03);
    host_rd_b(3'd0, "R4 host status pending");
    host_wr_b(3'd5, 8'hFF);
    core_rd(3'd2, 24'h0A0B0C, "R4 first word");
    core_rd(3'd2, 24'h010203, "R4 second word intact");
    core_rd(3'd1, stat_exp(), "R4 drained");

    // R3 16-bit and 8-bit
    core_wr(3'd0, 24'h42);
    host_wr_b(3'd5, 8'hAA); host_wr_b(3'd6, 8'h12); host_wr_b(3'd7, 8'h34);
    core_rd(3'd2, 24'h001234, "R3 16-bit word");
    core_wr(3'd0, 24'h40);
    host_wr_b(3'd6, 8'h77); host_wr_b(3'd7, 8'h56);
    core_rd(3'd2, 24'h000056, "R3 8-bit word");

    // R5 R6 transmit direction
    core_wr(3'd0, 24'h44);
    core_wr(3'd3, 24'hABCDEF);
    core_rd(3'd1, stat_exp(), "R5 moved to host reg");
    core_wr(3'd3, 24'h111213);
    core_rd(3'd1, stat_exp(), "R5 holding full");
    host_rd_b(3'd0, "R5 host status word waiting");
    host_rd_b(3'd5, "R6 high byte");
    host_rd_b(3'd6, "R6 mid byte");
    host_rd_b(3'd7, "R6 low byte");
    core_rd(3'd1, stat_exp(), "R5 empty after low read");
    host_rd_b(3'd5, "R6 second high");
    host_rd_b(3'd7, "R6 second low");
    host_rd_b(3'd0, "R5 host status none waiting");
    core_wr(3'd0, 24'h42);
    core_wr(3'd3, 24'h55BEEF);
    host_rd_b(3'd5, "R6 16-bit high reads zero");
    host_rd_b(3'd6, "R6 16-bit mid");
    host_rd_b(3'd7, "R6 16-bit low");

    // R7 unmapped index
    core_wr(3'd0, 24'h44);
    host_rd_b(3'd3, "R7 unmapped read");
    host_wr_b(3'd1, 8'h5A);
    core_rd(3'd1, stat_exp(), "R7 unmapped write no effect");

    // R9 host disabled
    core_wr(3'd0, 24'h04);
    host_wr_b(3'd7, 8'h99);
    core_rd(3'd1, stat_exp(), "R9 disabled write ignored");
    host_rd_b(3'd0, "R9 disabled read");

    // R8 multiplexed bus
    core_wr(3'd0, 24'h45);
    host_wr_b(3'd5, 8'hC1); host_wr_b(3'd6, 8'hC2); host_wr_b(3'd7, 8'hC3);
    core_rd(3'd2, 24'hC1C2C3, "R8 mux word");
    host_wr_b(3'd7, 8'hEE, 1);
    core_rd(3'd1, stat_exp(), "R8 wrong page ignored");
    host_wr_b(3'd7, 8'hEE, 2);
    core_rd(3'd1, stat_exp(), "R8 upper bits ignored");
    host_rd_b(3'd0, "R8 bad page read", 1);
    core_wr(3'd3, 24'h2468AC);
    host_rd_b(3'd6, "R8 mux mid read");
    host_rd_b(3'd7, "R8 mux low read");

    // R10 interrupt and DMA
    core_wr(3'd0, 24'h6C);
    host_wr_b(3'd5, 8'h00); host_wr_b(3'd6, 8'h00); host_wr_b(3'd7, 8'h01);
    chk("R10 irq on rx full", core_irq, 1);
    core_rd(3'd2, 24'h000001, "R10 rx word");
    core_wr(3'd0, 24'h54);
    chk("R10 irq on tx empty", core_irq, 1);

    // R11 GPIO
    core_wr(3'd4, 24'h00FF);
    core_wr(3'd5, 24'h000F);
    core_wr(3'd6, 24'h00A5);
    chk("R11 gp_oe value", gp_oe, 16'h000F);
    core_rd(3'd6, {8'h0, (m_sel & m_dir & m_dat) | (m_sel & ~m_dir & gp_i)}, "R11 data read");
    core_rd(3'd4, 24'h0000FF, "R11 enable readback");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule